// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs a four-phase measurement loop over and over: auto-zero, input integrate, reference deintegrate and integrator zero. For each phase it raises exactly one analog switch-enable output. The integrator, comparator, reference and input selection sit outside the block. The comparator reaches the block as a single digital input.

All timing runs off an internal tick, which is one clock enable every `CLK_DIV` input clocks. A programmable load value sets the length of both the auto-zero and the integrate phase. A smaller value gives a longer phase and so a finer resolution. At the end of integration the comparator level is captured as the input sign. Deintegration then counts ticks until the comparator leaves that level, or until a cap of twice the integrate length is reached. The count, the sign and an overrange flag are then written to a result register that holds them until the next conversion completes.

A hold input parks the loop in auto-zero so that, for example, the input selection can change. The active-low end-of-conversion output is low exactly while the block is in auto-zero. Its falling edge therefore marks fresh data.

Top module: `dslope_seq`

## Requirements
- R1: The phases always follow one another as auto-zero, integrate, deintegrate, integrator zero, and then auto-zero again. Exactly one of the four switch enables is high in every cycle.
- R2: One internal tick is `CLK_DIV` input clocks. Auto-zero and integrate each last (2^LOAD_W − L) × TICK_LEN ticks, where L is the active load value.
- R3: `res_sign` equals the level of `cmp_in` at the tick that ends integration.
- R4: A zero crossing means that `cmp_in` differs from the captured sign at a deintegrate tick. If a crossing is first seen at deintegrate tick m (counting from 1), the result is m−1 with `res_ovr`=0.
- R5: If no crossing is seen by deintegrate tick 2 × the integrate length, deintegration ends at that tick with `res_ovr`=1 and `res_mag` all ones. A crossing seen at that same tick still counts as a valid result.
- R6: The integrator-zero phase lasts `IZ_LEN` ticks.
- R7: While `hold` is high the block is in auto-zero from the next clock onward and does not leave it. After `hold` falls, a full auto-zero phase runs before integration.
- R8: `eoc_n` is 0 exactly in the cycles when auto-zero is active, and 1 in every other cycle.
- R9: The result outputs change only at the clock that ends a deintegrate phase. At all other times they hold their value, including across a hold.
- R10: A `load_stb` pulse captures `load_val` and restarts the loop in auto-zero on the next clock. The new value sets the length of the auto-zero and integrate phases that follow.
- R11: After `rst_n` is asserted the block is in auto-zero with `eoc_n`=0, and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, free-running |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Suspends conversion and parks the loop in auto-zero |
| load_stb | input | 1 | One-cycle strobe that captures `load_val` |
| load_val | input | LOAD_W (8) | Phase timer preload value |
| cmp_in | input | 1 | Comparator output level |
| sw_az | output | 1 | Auto-zero switch enable |
| sw_int | output | 1 | Input-integrate switch enable |
| sw_dint | output | 1 | Reference-deintegrate switch enable |
| sw_iz | output | 1 | Integrator-zero switch enable |
| eoc_n | output | 1 | End of conversion, low during auto-zero |
| res_mag | output | RES_W (17) | Latched deintegrate count |
| res_sign | output | 1 | Latched input polarity |
| res_ovr | output | 1 | Latched overrange flag |

## Verification
The main function is driven with several load values, including the minimum and maximum, and with both comparator polarities. This shows that the phase length follows the preload and that the sign capture is not tied to one level. The crossing is placed at the first deintegrate tick, at a middle tick and at the very last tick before the cap, and one run has no crossing at all. This separates an off-by-one in the count, a crossing-versus-cap priority error and a missing overrange. A hold is applied during integration, with a load strobe inside it. This shows that the result is kept, that the new load value governs the next phases, and that auto-zero has the same length as integration in steady running.

// File: rtl/dslope_seq_pkg.sv
package dslope_seq_pkg;

   typedef enum logic [1:0] {
      PH_AZ   = 2'd0,
      PH_INT  = 2'd1,
      PH_DINT = 2'd2,
      PH_IZ   = 2'd3
   } phase_e;

endpackage

// File: rtl/dslope_seq_prescale.sv
module dslope_seq_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_cnt
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/dslope_seq_phase_timer.sv
module dslope_seq_phase_timer #(
   parameter int LOAD_W   = 8,
   parameter int TICK_LEN = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              preload,
   input  logic [LOAD_W-1:0] start,
   input  logic              step,
   output logic              expire
);
   localparam int SUB_W = (TICK_LEN > 1) ? $clog2(TICK_LEN) : 1;
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICK_LEN - 1);

   logic [SUB_W-1:0]  sub_q;
   logic [LOAD_W-1:0] major_q;
   logic              sub_wrap;

   assign sub_wrap = (sub_q == SUB_LAST);
   assign expire   = step && sub_wrap && (&major_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q   <= '0;
         major_q <= '0;
      end else if (preload) begin
         sub_q   <= '0;
         major_q <= start;
      end else if (step) begin
         if (sub_wrap) begin
            sub_q   <= '0;
            major_q <= major_q + 1'b1;
         end else begin
            sub_q   <= sub_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dslope_seq_run_cnt.sv
module dslope_seq_run_cnt #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         step,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else if (step)  count <= count + 1'b1;
   end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
   import dslope_seq_pkg::*;
#(
   parameter int CLK_DIV  = 4,
   parameter int LOAD_W   = 8,
   parameter int TICK_LEN = 256,
   parameter int IZ_LEN   = 1024,
   parameter int RES_W    = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              load_stb,
   input  logic [LOAD_W-1:0] load_val,
   input  logic              cmp_in,
   output logic              sw_az,
   output logic              sw_int,
   output logic              sw_dint,
   output logic              sw_iz,
   output logic              eoc_n,
   output logic [RES_W-1:0]  res_mag,
   output logic              res_sign,
   output logic              res_ovr
);
   localparam int SPAN     = 2 ** LOAD_W;
   localparam int MAX_INT  = SPAN * TICK_LEN;
   localparam int CAP_MAX  = 2 * MAX_INT;
   localparam int RUN_SPAN = (CAP_MAX > IZ_LEN) ? CAP_MAX : IZ_LEN;
   localparam int RUN_W    = $clog2(RUN_SPAN + 1);

   generate
      if (CLK_DIV < 1)             begin : g_bad_div  $error("CLK_DIV must be at least 1");           end
      if (TICK_LEN < 1)            begin : g_bad_tick $error("TICK_LEN must be at least 1");          end
      if (IZ_LEN < 1)              begin : g_bad_iz   $error("IZ_LEN must be at least 1");            end
      if (LOAD_W < 1 || LOAD_W > 12) begin : g_bad_lw $error("LOAD_W out of range");                  end
      if (RES_W > 30)              begin : g_bad_rw   $error("RES_W too wide");                       end
      if (CAP_MAX > 2 ** RES_W)    begin : g_bad_cap  $error("RES_W cannot hold the deintegrate cap"); end
   endgenerate

   phase_e            phase_q;
   logic [LOAD_W-1:0] load_q;
   logic              sign_q;
   logic              tick;
   logic              tmr_expire;
   logic              tmr_preload;
   logic [LOAD_W-1:0] tmr_start;
   logic [RUN_W-1:0]  run;
   logic [RUN_W-1:0]  cap;
   logic              crossed;
   logic              cap_hit;
   logic              dint_end;
   logic              iz_end;
   logic              restart;

   dslope_seq_prescale #(.DIV(CLK_DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   assign restart     = hold || load_stb;
   assign tmr_start   = load_stb ? load_val : load_q;
   assign tmr_preload = restart
                     || (phase_q == PH_DINT) || (phase_q == PH_IZ)
                     || ((phase_q == PH_AZ) && tmr_expire);

   dslope_seq_phase_timer #(.LOAD_W(LOAD_W), .TICK_LEN(TICK_LEN)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .preload (tmr_preload),
      .start   (tmr_start),
      .step    (tick),
      .expire  (tmr_expire)
   );

   assign cap      = (RUN_W'(SPAN) - RUN_W'(load_q)) * RUN_W'(2 * TICK_LEN);
   assign crossed  = (cmp_in != sign_q);
   assign cap_hit  = (run == cap - 1'b1);
   assign dint_end = tick && (phase_q == PH_DINT) && (crossed || cap_hit);
   assign iz_end   = tick && (phase_q == PH_IZ) && (run == RUN_W'(IZ_LEN - 1));

   dslope_seq_run_cnt #(.W(RUN_W)) u_run (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (restart || (phase_q == PH_AZ) || (phase_q == PH_INT) || dint_end),
      .step  (tick && ((phase_q == PH_DINT) || (phase_q == PH_IZ))),
      .count (run)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_AZ;
         load_q   <= '0;
         sign_q   <= 1'b0;
         res_mag  <= '0;
         res_sign <= 1'b0;
         res_ovr  <= 1'b0;
      end else begin
         if (load_stb) load_q <= load_val;
         if (restart) begin
            phase_q <= PH_AZ;
         end else if (tick) begin
            unique case (phase_q)
               PH_AZ:   if (tmr_expire) phase_q <= PH_INT;
               PH_INT:  if (tmr_expire) begin
                           phase_q <= PH_DINT;
                           sign_q  <= cmp_in;
                        end
               PH_DINT: if (crossed || cap_hit) begin
                           phase_q  <= PH_IZ;
                           res_sign <= sign_q;
                           res_ovr  <= !crossed;
                           res_mag  <= crossed ? RES_W'(run) : '1;
                        end
               PH_IZ:   if (iz_end) phase_q <= PH_AZ;
               default: phase_q <= PH_AZ;
            endcase
         end
      end
   end

   assign sw_az   = (phase_q == PH_AZ);
   assign sw_int  = (phase_q == PH_INT);
   assign sw_dint = (phase_q == PH_DINT);
   assign sw_iz   = (phase_q == PH_IZ);
   assign eoc_n   = (phase_q != PH_AZ);
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
   parameter int RES_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hold,
   input logic             load_stb,
   input logic             sw_az,
   input logic             sw_int,
   input logic             sw_dint,
   input logic             sw_iz,
   input logic             eoc_n,
   input logic [RES_W-1:0] res_mag,
   input logic             res_sign,
   input logic             res_ovr
);
   a_r1_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({sw_az, sw_int, sw_dint, sw_iz}));

   a_r1_int_after_az: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_int) |-> $past(sw_az));

   a_r1_dint_after_int: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_dint) |-> $past(sw_int));

   a_r1_iz_after_dint: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_iz) |-> $past(sw_dint));

   a_r7_hold_parks: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> sw_az);

   a_r10_strobe_restart: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> sw_az);

   a_r8_eoc_tracks_az: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_n != sw_az);

   a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(sw_dint) |-> $stable({res_mag, res_sign, res_ovr}));

   a_r5_ovr_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      res_ovr |-> (&res_mag));
endmodule

bind dslope_seq dslope_seq_chk #(.RES_W(RES_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hold     (hold),
   .load_stb (load_stb),
   .sw_az    (sw_az),
   .sw_int   (sw_int),
   .sw_dint  (sw_dint),
   .sw_iz    (sw_iz),
   .eoc_n    (eoc_n),
   .res_mag  (res_mag),
   .res_sign (res_sign),
   .res_ovr  (res_ovr)
);

// File: tb/dslope_seq_tb_top.sv
`timescale 1ns/1ps
module dslope_seq_tb_top;
   localparam int DIV  = 4;
   localparam int LW   = 4;
   localparam int TICK = 2;
   localparam int IZL  = 3;
   localparam int RW   = 17;
   localparam int SPAN = 2 ** LW;
   localparam longint ONES = (64'd1 << RW) - 1;

   localparam int NV = 6;
   localparam int VLOAD [NV] = '{12, 12, 14, 14,  0, 15};
   localparam int VPOL  [NV] = '{ 1,  0,  1,  0,  1,  0};
   localparam int VFLIP [NV] = '{ 5,  1,  8,  0, 40,  3};

   logic          clk = 1'b0;
   logic          rst_n, hold, load_stb, cmp;
   logic [LW-1:0] load_val;
   logic          sw_az, sw_int, sw_dint, sw_iz, eoc_n, res_sign, res_ovr;
   logic [RW-1:0] res_mag;
   int            n_chk  = 0;
   int            n_fail = 0;
   bit            done   = 1'b0;

   always #2.5 clk = ~clk;

   dslope_seq #(.CLK_DIV(DIV), .LOAD_W(LW), .TICK_LEN(TICK), .IZ_LEN(IZL), .RES_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .hold(hold), .load_stb(load_stb), .load_val(load_val),
      .cmp_in(cmp), .sw_az(sw_az), .sw_int(sw_int), .sw_dint(sw_dint), .sw_iz(sw_iz),
      .eoc_n(eoc_n), .res_mag(res_mag), .res_sign(res_sign), .res_ovr(res_ovr));

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic strobe(input int ld);
      @(negedge clk);
      load_val = LW'(ld);
      load_stb = 1'b1;
      @(negedge clk);
      load_stb = 1'b0;
   endtask

   task automatic finish_dint(input int pol, input int flip, input int n);
      int len;
      if (flip > 0) begin
         repeat (DIV * flip - 1) @(posedge clk);
         @(negedge clk);
         cmp = ~pol[0];
         while (!sw_iz) @(negedge clk);
      end else begin
         len = 0;
         while (sw_dint) begin len++; @(negedge clk); end
         chk("R5 deintegrate stops at cap", len, 2 * n * DIV);
      end
      chk("R1 deintegrate followed by integrator zero", sw_iz, 1);
      chk("R3 sign captured", res_sign, pol);
      chk("R4 R5 magnitude", res_mag, (flip > 0) ? flip - 1 : ONES);
      chk("R5 overrange flag", res_ovr, (flip > 0) ? 0 : 1);
   endtask

   task automatic run_vec(input int ld, input int pol, input int flip);
      int n, len, bad;
      n = (SPAN - ld) * TICK;
      cmp = pol[0];
      strobe(ld);
      chk("R10 strobe restarts in auto-zero", sw_az, 1);
      chk("R8 eoc low in auto-zero", eoc_n, 0);
      while (!sw_int) @(negedge clk);
      len = 0; bad = 0;
      while (sw_int) begin
         if (eoc_n !== 1'b1) bad++;
         len++;
         @(negedge clk);
      end
      chk("R2 integrate length", len, n * DIV);
      chk("R8 eoc high during integrate", bad, 0);
      chk("R1 integrate followed by deintegrate", sw_dint, 1);
      finish_dint(pol, flip, n);
      len = 0;
      while (sw_iz) begin len++; @(negedge clk); end
      chk("R6 integrator zero length", len, IZL * DIV);
      chk("R1 back to auto-zero", sw_az, 1);
   endtask

   initial begin
      rst_n = 1'b0; hold = 1'b0; load_stb = 1'b0; load_val = '0; cmp = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11 reset auto-zero", {sw_az, sw_int, sw_dint, sw_iz}, 4'b1000);
      chk("R11 reset eoc", eoc_n, 0);
      chk("R11 reset result", {res_mag, res_sign, res_ovr}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) run_vec(VLOAD[v], VPOL[v], VFLIP[v]);

      // R7 R9 R10: hold during integrate, new load inside the hold
      begin
         int len, bad;
         cmp = 1'b1;
         strobe(12);
         while (!sw_int) @(negedge clk);
         repeat (3) @(negedge clk);
         hold = 1'b1;
         @(negedge clk);
         chk("R7 hold parks in auto-zero", sw_az, 1);
         chk("R8 eoc low under hold", eoc_n, 0);
         load_val = LW'(10); load_stb = 1'b1;
         @(negedge clk);
         load_stb = 1'b0;
         bad = 0;
         repeat (40) begin @(negedge clk); if (!sw_az) bad++; end
         chk("R7 stays in auto-zero while held", bad, 0);
         chk("R9 result kept across hold", res_mag, VFLIP[NV-1] - 1);
         chk("R9 sign kept across hold", res_sign, VPOL[NV-1]);
         hold = 1'b0;
         while (!sw_int) @(negedge clk);
         len = 0;
         while (sw_int) begin len++; @(negedge clk); end
         chk("R10 new load sets integrate length", len, (SPAN - 10) * TICK * DIV);
         finish_dint(1, 4, (SPAN - 10) * TICK);
         while (!sw_az) @(negedge clk);
         cmp = 1'b1;
         len = 0;
         while (sw_az) begin len++; @(negedge clk); end
         chk("R2 steady auto-zero length", len, (SPAN - 10) * TICK * DIV);
         chk("R1 auto-zero followed by integrate", sw_int, 1);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule